// File: doc/BRIEF.md
# Block Sum-of-Absolute-Differences Engine

This unit measures how far an 8x8 block of current-frame pixels is from an 8x8 block of reference pixels. It does this by summing the absolute gray-level differences of all 64 co-located pixel pairs. A motion search places one of these engines behind each candidate position and later keeps the candidate whose total is smallest. That selection is not part of this unit.

Data enters one column at a time. Each accepted beat carries eight 8-bit pixels of the current block and the eight matching reference pixels. Columns arrive from left to right, and eight beats make a block. Each row lane compares its two operands as unsigned numbers and keeps the larger one. It takes the one's complement of the smaller one. All sixteen lane terms and one constant equal to the row count are then compressed by a carry-save network into a sum word and a carry word. A single carry-lookahead adder merges those two words into the column's difference total. Column totals build up in a 22-bit register. One cycle after the eighth beat, the unit raises a one-cycle completion pulse, and the output holds the finished block total.

Top module: `sad_block_unit`

## Requirements
- R1: After reset, `done_o` is 0 and `sad_o` is 0.
- R2: After eight accepted beats, `sad_o` equals the sum over all 64 pairs of |cur - ref|, using unsigned 8-bit pixels. Pixel of row r sits at bits [8r+7:8r] of each column bus.
- R3: A pair with equal pixels adds exactly 0, so a block whose two sides are identical gives 0.
- R4: Extreme blocks of all 0 against all 255 give 16320, whichever side holds the 255s.
- R5: `done_o` is high for exactly one cycle, namely the cycle after the eighth accepted beat of a block. It is low at all other times.
- R6: Cycles with `beat_valid_i` low and `start_i` low change neither `sad_o` nor the column count, whatever the column buses carry.
- R7: `start_i` abandons any partial block. Alone, it sets `sad_o` to 0 in the next cycle. Together with a valid beat, that beat becomes the first column of a new block.
- R8: The finished total stays on `sad_o` until the next accepted beat. The beat after a finished block starts a fresh block without any `start_i`.
- R9: `sad_o` never exceeds 16320.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Abandon partial block and clear the total |
| beat_valid_i | input | 1 | Column buses carry a beat this cycle |
| cur_col_i | input | 64 | Eight current-block pixels of one column |
| ref_col_i | input | 64 | Eight reference-block pixels of the same column |
| done_o | output | 1 | One-cycle pulse: block total is ready |
| sad_o | output | 22 | Running, then final, block total |

## Verification
The hardest case to reach is the wrap of the one's-complement arithmetic. Only the right correction constant and the dropped top bit turn the inverted terms into exact differences. Equal pairs and the 0-versus-255 extremes sit right on that edge, so the table drives both orientations and also ramps that cross many pixel values. A second hard case is a start that arrives partway through a block, or together with a beat. The directed tests first push a few garbage columns to leave a partial count behind. They then apply start on its own and also start paired with a beat, and check the next block's total. Idle gaps carrying random data run between beats of the random blocks.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned PIX_W_DEF = 8;
  localparam int unsigned ROWS_DEF  = 8;
  localparam int unsigned COLS_DEF  = 8;
  localparam int unsigned ACC_W_DEF = 22;
  localparam int unsigned CLA_GRP   = 4;

  // width of one column's difference total (ROWS must be a power of two)
  function automatic int unsigned col_width(int unsigned pix_w, int unsigned rows);
    return pix_w + $clog2(rows);
  endfunction
endpackage

// File: rtl/sad_pair_prep.sv
module sad_pair_prep #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] cur_px_i,
  input  logic [PIX_W-1:0] ref_px_i,
  output logic [PIX_W-1:0] big_o,
  output logic [PIX_W-1:0] small_inv_o
);
  logic cur_ge;
  logic [PIX_W-1:0] small_px;

  always_comb begin
    cur_ge      = (cur_px_i >= ref_px_i);
    big_o       = cur_ge ? cur_px_i : ref_px_i;
    small_px    = cur_ge ? ref_px_i : cur_px_i;
    small_inv_o = ~small_px;
  end
endmodule

// File: rtl/sad_csa_tree.sv
module sad_csa_tree #(
  parameter int unsigned W = 11,
  parameter int unsigned N = 17
) (
  input  logic [W-1:0] terms_i [N],
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  function automatic int unsigned lvl_cnt(int unsigned lev);
    int unsigned n;
    n = N;
    for (int unsigned i = 0; i < 32; i++)
      if (i < lev) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  function automatic int unsigned lvl_total();
    int unsigned n;
    int unsigned l;
    n = N;
    l = 0;
    for (int unsigned i = 0; i < 32; i++)
      if (n > 2) begin
        n = 2 * (n / 3) + (n % 3);
        l++;
      end
    return l;
  endfunction

  localparam int unsigned NLEV = lvl_total();

  logic [W-1:0] node [NLEV+1][N];

  for (genvar k = 0; k < N; k++) begin : g_in
    assign node[0][k] = terms_i[k];
  end

  for (genvar lev = 0; lev < NLEV; lev++) begin : g_lvl
    localparam int unsigned CIN  = lvl_cnt(lev);
    localparam int unsigned NG   = CIN / 3;
    localparam int unsigned REM  = CIN % 3;
    localparam int unsigned COUT = 2 * NG + REM;
    for (genvar g = 0; g < NG; g++) begin : g_fa
      logic [W-1:0] x, y, z;
      assign x = node[lev][3*g];
      assign y = node[lev][3*g+1];
      assign z = node[lev][3*g+2];
      assign node[lev+1][2*g]   = x ^ y ^ z;
      assign node[lev+1][2*g+1] = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) |
                                   (y[W-2:0] & z[W-2:0]), 1'b0};
    end
    for (genvar r = 0; r < REM; r++) begin : g_pass
      assign node[lev+1][2*NG+r] = node[lev][3*NG+r];
    end
    for (genvar u = COUT; u < N; u++) begin : g_idle
      assign node[lev+1][u] = '0;
    end
  end

  assign sum_o   = node[NLEV][0];
  assign carry_o = node[NLEV][1];
endmodule

// File: rtl/sad_cla_adder.sv
module sad_cla_adder #(
  parameter int unsigned W   = 11,
  parameter int unsigned GRP = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int unsigned NG  = (W + GRP - 1) / GRP;
  localparam int unsigned NGL = (NG > 1) ? NG - 1 : 1;

  logic [NGL-1:0] grp_g, grp_p;
  logic [NG-1:0]  grp_c;
  logic [W-1:0]   bit_c;

  always_comb begin
    // group generate / propagate, flattened sum of products
    for (int unsigned gi = 0; gi < NGL; gi++) begin
      logic gg, prod;
      gg = 1'b0;
      for (int unsigned k = 0; k < GRP; k++) begin
        prod = a_i[gi*GRP+k] & b_i[gi*GRP+k];
        for (int unsigned m = k + 1; m < GRP; m++)
          prod = prod & (a_i[gi*GRP+m] ^ b_i[gi*GRP+m]);
        gg = gg | prod;
      end
      grp_g[gi] = (gi < NG - 1) ? gg : 1'b0;
      prod = 1'b1;
      for (int unsigned m = 0; m < GRP; m++)
        prod = prod & (a_i[gi*GRP+m] ^ b_i[gi*GRP+m]);
      grp_p[gi] = (gi < NG - 1) ? prod : 1'b0;
    end
    grp_c[0] = 1'b0;
    for (int unsigned gi = 1; gi < NG; gi++)
      grp_c[gi] = grp_g[gi-1] | (grp_p[gi-1] & grp_c[gi-1]);
    // carry into each bit from its group carry-in
    for (int unsigned i = 0; i < W; i++) begin
      logic cb, prod;
      int unsigned base;
      base = (i / GRP) * GRP;
      prod = grp_c[i/GRP];
      for (int unsigned m = base; m < i; m++)
        prod = prod & (a_i[m] ^ b_i[m]);
      cb = prod;
      for (int unsigned k = base; k < i; k++) begin
        prod = a_i[k] & b_i[k];
        for (int unsigned m = k + 1; m < i; m++)
          prod = prod & (a_i[m] ^ b_i[m]);
        cb = cb | prod;
      end
      bit_c[i] = cb;
    end
    sum_o = a_i ^ b_i ^ bit_c;
  end
endmodule

// File: rtl/sad_column_unit.sv
module sad_column_unit
  import sad_pkg::*;
#(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ROWS  = 8,
  localparam int unsigned COL_W = col_width(PIX_W, ROWS)
) (
  input  logic [ROWS*PIX_W-1:0] cur_col_i,
  input  logic [ROWS*PIX_W-1:0] ref_col_i,
  output logic [COL_W-1:0]      col_sad_o
);
  localparam int unsigned NT = 2 * ROWS + 1;

  logic [COL_W-1:0] terms [NT];
  logic [COL_W-1:0] tree_sum, tree_carry;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [PIX_W-1:0] big, small_inv;
    sad_pair_prep #(.PIX_W(PIX_W)) u_pair (
      .cur_px_i   (cur_col_i[r*PIX_W +: PIX_W]),
      .ref_px_i   (ref_col_i[r*PIX_W +: PIX_W]),
      .big_o      (big),
      .small_inv_o(small_inv)
    );
    assign terms[2*r]   = COL_W'(big);
    assign terms[2*r+1] = COL_W'(small_inv);
  end
  // one +1 per inverted lane; the excess ROWS*2^PIX_W wraps out of COL_W
  assign terms[NT-1] = COL_W'(ROWS);

  sad_csa_tree #(.W(COL_W), .N(NT)) u_tree (
    .terms_i(terms),
    .sum_o  (tree_sum),
    .carry_o(tree_carry)
  );

  sad_cla_adder #(.W(COL_W), .GRP(CLA_GRP)) u_cla (
    .a_i  (tree_sum),
    .b_i  (tree_carry),
    .sum_o(col_sad_o)
  );
endmodule

// File: rtl/sad_block_unit.sv
module sad_block_unit
  import sad_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_DEF,
  parameter int unsigned ROWS  = ROWS_DEF,
  parameter int unsigned COLS  = COLS_DEF,
  parameter int unsigned ACC_W = ACC_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  beat_valid_i,
  input  logic [ROWS*PIX_W-1:0] cur_col_i,
  input  logic [ROWS*PIX_W-1:0] ref_col_i,
  output logic                  done_o,
  output logic [ACC_W-1:0]      sad_o
);
  localparam int unsigned COL_W = col_width(PIX_W, ROWS);
  localparam int unsigned CNT_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [CNT_W-1:0] LAST_COL = CNT_W'(COLS - 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [COL_W-1:0] col_sad;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic [ACC_W-1:0] acc_q, acc_d, acc_base;
  logic             done_q, done_d;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sad_column_unit #(.PIX_W(PIX_W), .ROWS(ROWS)) u_col (
    .cur_col_i(cur_col_i),
    .ref_col_i(ref_col_i),
    .col_sad_o(col_sad)
  );

  always_comb begin
    cnt_base = start_i ? '0 : cnt_q;
    acc_base = (start_i || cnt_base == '0) ? '0 : acc_q;
    cnt_d    = cnt_q;
    acc_d    = start_i ? '0 : acc_q;
    done_d   = 1'b0;
    if (beat_valid_i) begin
      acc_d  = acc_base + ACC_W'(col_sad);
      cnt_d  = (cnt_base == LAST_COL) ? '0 : cnt_base + 1'b1;
      done_d = (cnt_base == LAST_COL);
    end else if (start_i) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (beat_valid_i || start_i) begin
        cnt_q <= cnt_d;
        acc_q <= acc_d;
      end
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
  assign sad_o  = acc_q;
endmodule

// File: rtl/sad_block_unit_chk.sv
module sad_block_unit_chk #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned COLS  = 8,
  parameter int unsigned ACC_W = 22
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  beat_valid_i,
  input logic                  done_o,
  input logic [ACC_W-1:0]      sad_o
);
  localparam logic [ACC_W-1:0] MAX_SAD = ACC_W'(ROWS * COLS * ((1 << PIX_W) - 1));

  // R5: the pulse lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: a pulse is always caused by an accepted beat
  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(beat_valid_i));

  // R6 and R8: idle cycles leave the total alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid_i && !start_i) |=> $stable(sad_o));

  // R7: start on its own clears the total and gives no pulse
  a_r7_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !beat_valid_i) |=> (sad_o == '0 && !done_o));

  // R9: the total stays inside its reachable range
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    sad_o <= MAX_SAD);
endmodule

bind sad_block_unit sad_block_unit_chk #(
  .PIX_W(PIX_W), .ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .beat_valid_i(beat_valid_i),
  .done_o      (done_o),
  .sad_o       (sad_o)
);

// File: tb/sad_block_unit_tb.sv
module sad_block_unit_tb;
  localparam int NPIX = 64;
  localparam int NVEC = 7;
  // entry: {cur_base, cur_step, ref_base, ref_step}; pixel k = base + step*k (mod 256)
  localparam logic [31:0] VEC [NVEC] = '{
    32'h00_00_00_00,   // R3 all zero on both sides
    32'h37_03_37_03,   // R3 identical ramps
    32'h00_00_FF_00,   // R4 reference holds 255s
    32'hFF_00_00_00,   // R4 current holds 255s
    32'h00_01_3F_FF,   // R2 opposing ramps
    32'h0A_07_C8_0D,   // R2 wrapping ramps
    32'h80_00_00_04    // R2 flat against ramp
  };

  logic        clk, rst_n, start_i, beat_valid_i;
  logic [63:0] cur_col_i, ref_col_i;
  logic        done_o;
  logic [21:0] sad_o;
  logic [7:0]  cur_px [NPIX];
  logic [7:0]  ref_px [NPIX];
  int checks, fails;
  bit finished;

  sad_block_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .beat_valid_i(beat_valid_i),
    .cur_col_i(cur_col_i), .ref_col_i(ref_col_i), .done_o(done_o), .sad_o(sad_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic int model_sad();
    int s;
    s = 0;
    for (int k = 0; k < NPIX; k++)
      s += (cur_px[k] > ref_px[k]) ? int'(cur_px[k]) - int'(ref_px[k])
                                   : int'(ref_px[k]) - int'(cur_px[k]);
    return s;
  endfunction

  task automatic drive_col(input int c);
    for (int r = 0; r < 8; r++) begin
      cur_col_i[8*r +: 8] = cur_px[8*c+r];
      ref_col_i[8*r +: 8] = ref_px[8*c+r];
    end
  endtask

  task automatic garbage_beats(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      beat_valid_i = 1'b1;
      cur_col_i = {$urandom, $urandom};
      ref_col_i = {$urandom, $urandom};
    end
    @(negedge clk);
    beat_valid_i = 1'b0;
  endtask

  // sends the loaded block, checks the pulse, the total and the hold
  task automatic send_block(input int gap_max, input bit start_first, input string tag);
    int exp;
    exp = model_sad();
    for (int c = 0; c < 8; c++) begin
      int gaps;
      gaps = (gap_max > 0) ? int'($urandom_range(gap_max, 0)) : 0;
      for (int g = 0; g < gaps; g++) begin
        @(negedge clk);
        beat_valid_i = 1'b0;
        start_i = 1'b0;
        cur_col_i = {$urandom, $urandom};
        ref_col_i = {$urandom, $urandom};
      end
      @(negedge clk);
      if (c > 0) check(done_o == 1'b0, {tag, " R5 no early pulse"}, done_o, 0);
      beat_valid_i = 1'b1;
      start_i = start_first && (c == 0);
      drive_col(c);
    end
    @(negedge clk);
    beat_valid_i = 1'b0;
    start_i = 1'b0;
    cur_col_i = {$urandom, $urandom};
    check(done_o == 1'b1, {tag, " R5 pulse"}, done_o, 1);
    check(sad_o == 22'(exp), {tag, " R2 total"}, sad_o, exp);
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R5 pulse width"}, done_o, 0);
    check(sad_o == 22'(exp), {tag, " R8 hold"}, sad_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    start_i = 1'b0;
    beat_valid_i = 1'b0;
    cur_col_i = '0;
    ref_col_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done after reset", done_o, 0);
    check(sad_o == 22'd0, "R1 total after reset", sad_o, 0);

    // table walk, blocks back to back without start (R8 fresh block)
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < NPIX; k++) begin
        cur_px[k] = VEC[v][31:24] + VEC[v][23:16] * 8'(k);
        ref_px[k] = VEC[v][15:8]  + VEC[v][7:0]   * 8'(k);
      end
      send_block(0, 1'b0, $sformatf("vec%0d", v));
    end
    // explicit extreme values (R4) and zero (R3) from the table
    for (int k = 0; k < NPIX; k++) begin cur_px[k] = 8'd255; ref_px[k] = 8'd0; end
    send_block(0, 1'b0, "R4 extreme");
    check(sad_o == 22'd16320, "R4 value", sad_o, 16320);

    // R6: random blocks with idle gaps carrying garbage
    for (int b = 0; b < 20; b++) begin
      for (int k = 0; k < NPIX; k++) begin
        cur_px[k] = 8'($urandom);
        ref_px[k] = 8'($urandom);
      end
      send_block(3, 1'b0, "R6 gapped random");
    end

    // R7: start alone after a partial block
    garbage_beats(3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(sad_o == 22'd0, "R7 start clears", sad_o, 0);
    check(done_o == 1'b0, "R7 no pulse", done_o, 0);
    for (int k = 0; k < NPIX; k++) begin cur_px[k] = 8'($urandom); ref_px[k] = 8'($urandom); end
    send_block(0, 1'b0, "R7 after start");

    // R7: start together with the first beat after a partial block
    garbage_beats(5);
    for (int k = 0; k < NPIX; k++) begin cur_px[k] = 8'($urandom); ref_px[k] = 8'($urandom); end
    send_block(0, 1'b1, "R7 start with beat");

    // R8: long idle keeps the total
    begin
      logic [21:0] held;
      held = sad_o;
      repeat (5) @(negedge clk);
      check(sad_o == held, "R8 long hold", sad_o, held);
    end
    finish_run();
  end
endmodule